// File: doc/BRIEF.md
# Input Capture Channel with Edge Select

This block timestamps transitions on an asynchronous external pin. The pin first passes through a synchroniser. An edge detector then picks out either rising or falling transitions, as chosen by a select input. On each transition it picks, the block copies the value of an externally supplied free-running counter into a 16-bit capture register that the CPU can only read. The counter itself is not part of this block.

The CPU reads the captured time as two bytes. Reading the high byte first freezes the capture register until the low byte is read, so the two halves always belong to the same event. Transitions that arrive during the freeze still raise the capture flag, but their timestamps are dropped. The flag drives an interrupt request when the enable input is set, and it stays set until software clears it.

Top module: `capture_channel`

## Requirements
- R1: With the default two synchroniser stages, a pin change placed between two clock edges is acted on at the third rising clock edge after it. The capture register takes the counter value present just before that edge. The flag becomes visible after that same edge and not before.
- R2: When edge_rise_i is 1, only 0-to-1 transitions of the synchronised pin qualify. When it is 0, only 1-to-0 transitions qualify. A transition in the other direction neither sets the flag nor changes the capture register.
- R3: Every qualifying transition that is not suppressed loads the capture register, whether the flag is already set or clear.
- R4: A cycle with rd_hi_i high starts a freeze that lasts until a cycle with rd_lo_i high. Qualifying transitions detected during the freeze, including one in the cycle of the high read itself, leave the capture register unchanged.
- R5: A low-byte read on its own does not start a freeze. A low-byte read in the same cycle as a detection ends the freeze, and that detection loads the register.
- R6: The flag is set by every qualifying transition, including suppressed ones. It is cleared by flag_clr_i. If a set and a clear fall in the same cycle, the set wins.
- R7: irq_o is high exactly when the flag is set and irq_en_i is high.
- R8: Reset clears the flag, the freeze and the synchroniser and edge history to 0. Reset does not alter the contents of the capture register.
- R9: rd_data_o shows capture bits 15:8 while rd_hi_i is high, and bits 7:0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Free-running counter value |
| pin_i | input | 1 | Asynchronous capture pin |
| edge_rise_i | input | 1 | 1 selects rising transitions, 0 selects falling ones |
| irq_en_i | input | 1 | Capture interrupt enable |
| flag_clr_i | input | 1 | Clears the capture flag |
| rd_hi_i | input | 1 | High-byte read strobe; also selects the high byte |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_data_o | output | 8 | Selected byte of the capture register |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a transition that lands while the register is frozen. It has to keep the old timestamp and still raise the flag. To reach it, the stimulus reads the high byte and then toggles the pin through a full cycle, so that a qualifying transition passes the synchroniser before any low-byte read. Next, a low-byte read alone must show that a fresh transition loads again, and a mid-run reset must leave the captured bytes unchanged. Every cycle, a queue-based model of the pin history predicts the flag, the interrupt and the read byte, which are then compared with the outputs.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  edge_kind_e sel_i,
  output logic       hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = lvl_i & ~prev_q;
      default:   hit_o = ~lvl_i & prev_q;
    endcase
  end

  // R2: a hit cannot repeat on the very next cycle while the select holds
  p_hit_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && $stable(sel_i)) |=> (!hit_o || !$stable(sel_i)));
endmodule

// File: rtl/cap_read_lock.sv
module cap_read_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_hi_i,
  input  logic rd_lo_i,
  output logic block_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= 1'b0;
    else if (rd_lo_i) lock_q <= 1'b0;
    else if (rd_hi_i) lock_q <= 1'b1;
  end

  // a high read blocks in its own cycle; a low read releases in its own cycle
  assign block_o = rd_hi_i | (lock_q & ~rd_lo_i);

  p_lock_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i) |=> lock_q);
  p_lock_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> !lock_q);
endmodule

// File: rtl/capture_channel.sv
module capture_channel
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_i,
  input  logic             edge_rise_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  input  logic             rd_hi_i,
  input  logic             rd_lo_i,
  output logic [7:0]       rd_data_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam int HALF_W = CNT_W / 2;

  logic             pin_sync;
  logic             hit;
  logic             blocked;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  cap_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pin_sync),
    .sel_i  (edge_kind_e'(edge_rise_i)),
    .hit_o  (hit)
  );

  cap_read_lock u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_hi_i (rd_hi_i),
    .rd_lo_i (rd_lo_i),
    .block_o (blocked)
  );

  // capture register is deliberately outside reset
  always_ff @(posedge clk_i) begin
    if (hit && !blocked) cap_q <= cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (hit)        flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign rd_data_o = rd_hi_i ? cap_q[CNT_W-1:HALF_W] : cap_q[HALF_W-1:0];
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & irq_en_i;

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !blocked) |=> (cap_q == $past(cnt_i)));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i && !hit) |=> $stable(cap_q));
  p_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_o);
  p_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (!irq_en_i || irq_o));
endmodule

// File: tb/capture_channel_bench.sv
module capture_channel_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'hFFFC;
  logic [1:0]  pre = 2'd0;
  logic        pin = 1'b0, edge_rise = 1'b1, irq_en = 1'b0, flag_clr = 1'b0;
  logic        rd_hi = 1'b0, rd_lo = 1'b0;
  logic [7:0]  rd_data;
  logic        flag, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  capture_channel u_capture_channel (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .pin_i(pin),
    .edge_rise_i(edge_rise), .irq_en_i(irq_en), .flag_clr_i(flag_clr),
    .rd_hi_i(rd_hi), .rd_lo_i(rd_lo), .rd_data_o(rd_data),
    .flag_o(flag), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // counter advances once per four bus clocks
  always @(posedge clk) begin
    pre <= pre + 2'd1;
    if (pre == 2'd3) cnt <= cnt + 16'd1;
  end

  // reference model
  int  hist[$];
  int  m_cap = 0;
  bit  m_valid = 0, m_flag = 0, m_lock = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_flag = 0;
      m_lock = 0;
    end else begin
      bit det, blk;
      if (edge_rise) det = (hist[1] == 1) && (hist[2] == 0);
      else           det = (hist[1] == 0) && (hist[2] == 1);
      blk = rd_hi || (m_lock && !rd_lo);
      if (det && !blk) begin m_cap = int'(cnt); m_valid = 1; end
      if (det) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (rd_lo) m_lock = 0; else if (rd_hi) m_lock = 1;
      hist.push_front(int'(pin));
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (!done) begin
      check("R6 flag", int'(flag), int'(m_flag));
      check("R7 irq", int'(irq), int'(m_flag && irq_en));
      if (m_valid)
        check("R9 byte", int'(rd_data), rd_hi ? ((m_cap >> 8) & 255) : (m_cap & 255));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_hi; @(negedge clk); rd_hi = 1; @(negedge clk); rd_hi = 0; endtask
  task automatic pulse_lo; @(negedge clk); rd_lo = 1; @(negedge clk); rd_lo = 0; endtask
  task automatic clear_flag; @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0; endtask

  int saved, exp_cnt;

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    #3;
    check("R8 reset flag", int'(flag), 0);
    check("R8 reset irq", int'(irq), 0);
    @(negedge clk); rst_n = 1; irq_en = 1;
    cyc(3);

    // R1: latency and sampled counter value
    @(negedge clk); pin = 1;
    cyc(2); #3;
    check("R1 flag early", int'(flag), 0);
    exp_cnt = int'(cnt);
    cyc(1); #3;
    check("R1 flag on time", int'(flag), 1);
    check("R7 irq on", int'(irq), 1);
    check("R1 low byte", int'(rd_data), exp_cnt & 255);
    @(negedge clk); rd_hi = 1; #3;
    check("R9 high byte", int'(rd_data), (exp_cnt >> 8) & 255);
    @(negedge clk); rd_hi = 0; rd_lo = 1;
    @(negedge clk); rd_lo = 0;
    saved = exp_cnt;

    // R2: falling edge ignored while rising selected
    clear_flag();
    @(negedge clk); pin = 0;
    cyc(6); #3;
    check("R2 wrong edge flag", int'(flag), 0);
    check("R2 wrong edge data", int'(rd_data), saved & 255);
    // select falling: rising ignored, falling captured
    @(negedge clk); edge_rise = 0; pin = 1;
    cyc(6); #3;
    check("R2 rise ignored", int'(flag), 0);
    @(negedge clk); pin = 0;
    cyc(2); #3; exp_cnt = int'(cnt);
    cyc(1); #3;
    check("R2 fall flag", int'(flag), 1);
    check("R2 fall data", int'(rd_data), exp_cnt & 255);

    // R3: load again with flag still set
    cyc(8);
    @(negedge clk); pin = 1;
    cyc(4);
    @(negedge clk); pin = 0;
    cyc(2); #3; exp_cnt = int'(cnt);
    cyc(1); #3;
    check("R3 reload with flag set", int'(rd_data), exp_cnt & 255);
    saved = exp_cnt;

    // R4: freeze after high read
    edge_rise = 1;
    clear_flag();
    pulse_hi();
    @(negedge clk); pin = 1;
    cyc(12); #3;
    check("R4 frozen data", int'(rd_data), saved & 255);
    check("R6 flag while frozen", int'(flag), 1);
    @(negedge clk); pin = 0;
    cyc(4);
    pulse_lo();
    @(negedge clk); pin = 1;
    cyc(2); #3; exp_cnt = int'(cnt);
    cyc(1); #3;
    check("R4 load after low read", int'(rd_data), exp_cnt & 255);

    // R5: low read alone does not freeze
    @(negedge clk); pin = 0;
    cyc(4);
    pulse_lo();
    cyc(4);
    @(negedge clk); pin = 1;
    cyc(2); #3; exp_cnt = int'(cnt);
    cyc(1); #3;
    check("R5 load after lone low read", int'(rd_data), exp_cnt & 255);
    // R5: low read in detection cycle while frozen
    @(negedge clk); pin = 0;
    cyc(4);
    pulse_hi();
    @(negedge clk); pin = 1;
    cyc(1);
    @(negedge clk); rd_lo = 1; #3; exp_cnt = int'(cnt);
    @(negedge clk); rd_lo = 0; #3;
    check("R5 release same cycle", int'(rd_data), exp_cnt & 255);
    saved = exp_cnt;

    // R6: clear and set together, set wins
    @(negedge clk); pin = 0;
    cyc(4);
    @(negedge clk); pin = 1;
    cyc(1);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0; #3;
    check("R6 set beats clear", int'(flag), 1);
    saved = int'(rd_data);
    @(negedge clk); irq_en = 0; #3;
    check("R7 irq masked", int'(irq), 0);

    // R8: reset keeps capture contents
    @(negedge clk); pin = 0;
    cyc(4);
    @(negedge clk); rd_hi = 1; #3; exp_cnt = int'(rd_data);
    @(negedge clk); rd_hi = 0; #3; saved = int'(rd_data);
    rst_n = 0;
    cyc(3); #3;
    check("R8 flag after reset", int'(flag), 0);
    check("R8 low kept", int'(rd_data), saved);
    @(negedge clk); rst_n = 1; rd_hi = 1; #3;
    check("R8 high kept", int'(rd_data), exp_cnt);
    @(negedge clk); rd_hi = 0; rd_lo = 1;
    @(negedge clk); rd_lo = 0;
    cyc(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule